// File: doc/BRIEF.md
# Signed-Count Arithmetic and Logical Shifter

This block shifts an 8-, 16- or 32-bit operand by a signed count and returns the shifted value together with carry, overflow, sign and zero flags. The count is a single byte read as a two's-complement number. A positive count shifts toward the most significant bit and a negative count shifts toward the least significant bit by the magnitude. A mode input picks arithmetic or logical behaviour.

Every count from -128 to +127 has a defined result. This includes a count of zero and counts equal to or larger than the operand width. In arithmetic mode, a left shift raises overflow when any bit that passes through the sign position differs from the original sign. The result and all four flags are captured in output registers, so each accepted operation appears on the outputs exactly one cycle after its strobe.

Operand fetch and writeback belong to the surrounding datapath. This block only computes the result and the flags.

Top module: `shift_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge, carrying that operation's results. When `in_valid` is low, `out_valid` drops after the edge and `out_data` and the flags keep their previous values. After reset, every output is 0.
- R2: `in_count` is read as a signed byte. A value from 1 to 127 shifts left, and a value from 0x80 (-128) to 0xFF (-1) shifts right by its magnitude of 128 down to 1.
- R3: A count of zero returns the operand unchanged, with carry 0 and overflow 0.
- R4: In logical mode (`in_arith` = 0), a left shift by n fills with zeros and gives overflow 0. Carry is the last bit pushed out of the MSB, which is operand bit W-n for n <= W. For n >= W the result is 0.
- R5: In logical mode, a right shift by n fills the vacated bits with zeros. Carry is operand bit n-1 for n <= W and overflow is 0. For n >= W the result is 0.
- R6: In arithmetic mode (`in_arith` = 1), a left shift by n sets overflow when the top min(n,W) bits of the operand are not all equal to the operand's sign bit.
- R7: In arithmetic mode, a left shift by n gives operand<<n with zero fill and carry = operand bit W-n for n <= W. For n >= W the result is 0.
- R8: In arithmetic mode, a right shift by n copies the sign bit into the vacated bits. Carry is operand bit n-1 for n <= W and overflow is 0. For n >= W every result bit equals the sign bit.
- R9: The sign flag equals bit W-1 of the result. The zero flag is 1 exactly when the W-bit result is all zeros.
- R10: Width code `in_width` selects W: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits at W and above are ignored, and `out_data` bits at W and above are 0.
- R11: In every mode, when the magnitude n is greater than W, carry is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| in_valid | input | 1 | Operation strobe; the inputs below are captured when high |
| in_data | input | 32 | Operand; only the low W bits are used |
| in_count | input | 8 | Signed shift count |
| in_width | input | 2 | Operand width code (0: 8, 1: 16, 2/3: 32) |
| in_arith | input | 1 | 1 selects arithmetic mode, 0 selects logical mode |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 32 | Shifted value, zero above W |
| out_carry | output | 1 | Carry flag |
| out_ovf | output | 1 | Overflow flag |
| out_sign | output | 1 | Sign flag (result bit W-1) |
| out_zero | output | 1 | Zero flag |

## Verification
Every result and all four flags come from the same single register stage. They are due at the first rising edge after the strobe is sampled, with no other latency. The bench drives inputs on falling edges and queues one expected item per strobe. It compares on the next falling edge, after the output register has settled. On falling edges that carry no result, it checks that the outputs have held their previous values. At the end, the expected-item queue must be empty, which shows that no result arrived early, late or twice.

// File: rtl/shift_pkg.sv
package shift_pkg;

  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    WSEL_8   = 2'd0,
    WSEL_16  = 2'd1,
    WSEL_32  = 2'd2,
    WSEL_32B = 2'd3
  } wsel_e;

  typedef struct packed {
    logic             left;
    logic             zero;
    logic [CNT_W-1:0] mag;
  } cnt_info_t;

endpackage

// File: rtl/shift_count_decode.sv
module shift_count_decode
  import shift_pkg::*;
(
  input  logic [CNT_W-1:0] count,
  output cnt_info_t        info
);

  logic negative;

  always_comb begin
    negative  = count[CNT_W-1];
    info.zero = (count == '0);
    info.left = !negative && (count != '0);
    // magnitude of -128 is 128, which still fits unsigned in CNT_W bits
    info.mag  = negative ? (~count + 1'b1) : count;
  end

endmodule

// File: rtl/shift_lane.sv
module shift_lane
  import shift_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] op,
  input  cnt_info_t         ci,
  input  logic              arith,
  output logic [LANE_W-1:0] res,
  output logic              carry,
  output logic              ovf
);

  localparam int               SH_W = $clog2(LANE_W);
  localparam logic [CNT_W-1:0] W_C  = CNT_W'(LANE_W);

  logic                     big;
  logic                     beyond;
  logic                     sgn;
  logic [SH_W-1:0]          sh;
  logic [LANE_W-1:0]        top_mask;
  logic [CNT_W-1:0]         lpos;
  logic [CNT_W-1:0]         rpos;
  logic [LANE_W-1:0]        ltap;
  logic [LANE_W-1:0]        rtap;
  logic signed [LANE_W-1:0] sop;
  logic signed [LANE_W-1:0] sra;

  always_comb begin
    big      = (ci.mag >= W_C);
    beyond   = (ci.mag > W_C);
    sgn      = op[LANE_W-1];
    sh       = ci.mag[SH_W-1:0];
    // ones in the top min(mag, LANE_W) positions
    top_mask = ~({LANE_W{1'b1}} >> ci.mag);
    lpos     = W_C - ci.mag;
    rpos     = ci.mag - 1'b1;
    ltap     = op >> lpos;
    rtap     = op >> rpos;
    sop      = op;
    sra      = sop >>> sh;
  end

  always_comb begin
    res   = op;
    carry = 1'b0;
    ovf   = 1'b0;
    if (!ci.zero) begin
      if (ci.left) begin
        res   = big ? '0 : (op << sh);
        carry = beyond ? 1'b0 : ltap[0];
        if (arith) begin
          ovf = sgn ? ((op & top_mask) != top_mask)
                    : ((op & top_mask) != '0);
        end
      end else begin
        if (big) begin
          res = arith ? {LANE_W{sgn}} : '0;
        end else begin
          res = arith ? LANE_W'(sra) : (op >> sh);
        end
        carry = beyond ? 1'b0 : rtap[0];
      end
    end
  end

endmodule

// File: rtl/shift_flag_gen.sv
module shift_flag_gen #(
  parameter int DATA_W    = 32,
  parameter int NUM_LANES = 3,
  parameter int LSEL_W    = 2
) (
  input  logic [DATA_W-1:0] res,
  input  logic [LSEL_W-1:0] lane,
  output logic              sign,
  output logic              zero
);

  logic [NUM_LANES-1:0] msbs;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_msb
    assign msbs[g] = res[(8 << g) - 1];
  end

  always_comb begin
    sign = msbs[lane];
    zero = (res == '0);
  end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [1:0]        in_width,
  input  logic              in_arith,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_carry,
  output logic              out_ovf,
  output logic              out_sign,
  output logic              out_zero
);

  localparam int NUM_LANES = $clog2(DATA_W / 8) + 1;
  localparam int LSEL_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  cnt_info_t          ci;
  logic [DATA_W-1:0]  lane_res [NUM_LANES];
  logic [NUM_LANES-1:0] lane_cy;
  logic [NUM_LANES-1:0] lane_ov;
  logic [LSEL_W-1:0]  lane_sel;
  logic [DATA_W-1:0]  sel_res;
  logic               sel_sign;
  logic               sel_zero;

  logic               vld_q;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               cy_q, cy_d;
  logic               ov_q, ov_d;
  logic               s_q, s_d;
  logic               z_q, z_d;

  shift_count_decode u_dec (
    .count (in_count),
    .info  (ci)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] r;
    logic          c;
    logic          o;
    shift_lane #(.LANE_W(LW)) u_lane (
      .op    (in_data[LW-1:0]),
      .ci    (ci),
      .arith (in_arith),
      .res   (r),
      .carry (c),
      .ovf   (o)
    );
    assign lane_res[g] = DATA_W'(r);
    assign lane_cy[g]  = c;
    assign lane_ov[g]  = o;
  end

  always_comb begin
    if (int'(in_width) >= NUM_LANES - 1) begin
      lane_sel = LSEL_W'(NUM_LANES - 1);
    end else begin
      lane_sel = LSEL_W'(in_width);
    end
    sel_res = lane_res[lane_sel];
  end

  shift_flag_gen #(
    .DATA_W    (DATA_W),
    .NUM_LANES (NUM_LANES),
    .LSEL_W    (LSEL_W)
  ) u_flags (
    .res  (sel_res),
    .lane (lane_sel),
    .sign (sel_sign),
    .zero (sel_zero)
  );

  // next-state
  always_comb begin
    data_d = sel_res;
    cy_d   = lane_cy[lane_sel];
    ov_d   = lane_ov[lane_sel];
    s_d    = sel_sign;
    z_d    = sel_zero;
  end

  // registers, loaded only on an accepted operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      cy_q   <= 1'b0;
      ov_q   <= 1'b0;
      s_q    <= 1'b0;
      z_q    <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        data_q <= data_d;
        cy_q   <= cy_d;
        ov_q   <= ov_d;
        s_q    <= s_d;
        z_q    <= z_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_carry = cy_q;
  assign out_ovf   = ov_q;
  assign out_sign  = s_q;
  assign out_zero  = z_q;

  // ---------------- assertions ----------------
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_carry)));

  a_r3_zero_count_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_count == '0) |=> (!out_carry && !out_ovf));

  a_r4_logic_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_arith) |=> !out_ovf);

  a_r8_arith_right_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_arith && in_count[CNT_W-1]) |=> !out_ovf);

  a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_data == '0)));

  a_r10_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_width == WSEL_8) |=> (out_data[DATA_W-1:8] == '0));

  a_r11_far_carry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (int'(ci.mag) > (8 << lane_sel))) |=> !out_carry);

endmodule

// File: tb/test_shift_unit.sv
module test_shift_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [7:0]  in_count = '0;
  logic [1:0]  in_width = '0;
  logic        in_arith = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_carry, out_ovf, out_sign, out_zero;

  always #5 clk = ~clk;

  shift_unit i_shift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_count(in_count), .in_width(in_width), .in_arith(in_arith),
    .out_valid(out_valid), .out_data(out_data), .out_carry(out_carry),
    .out_ovf(out_ovf), .out_sign(out_sign), .out_zero(out_zero)
  );

  typedef struct {
    logic [31:0] d;
    logic        cy, ov, s, z;
    logic        arl;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  bit          have_last = 1'b0;
  logic [31:0] last_data;

  function automatic exp_t model(input logic [31:0] d, input logic [7:0] c,
                                 input logic [1:0] wc, input logic ar);
    exp_t        e;
    int          w;
    int          n;
    logic [31:0] m;
    logic [31:0] v;
    logic        sg;
    w  = (wc == 2'd0) ? 8 : (wc == 2'd1) ? 16 : 32;
    m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    v  = d & m;
    sg = v[w-1];
    e.cy = 1'b0; e.ov = 1'b0; e.arl = 1'b0; e.tag = "";
    n = 0;
    if (c != 8'd0 && !c[7]) begin
      n = int'(c);
      e.arl = ar;
      for (int i = 0; i < n; i++) begin
        e.cy = v[w-1];
        if (ar && i < w && v[w-1] != sg) e.ov = 1'b1;
        v = (v << 1) & m;
      end
    end else if (c[7]) begin
      n = 256 - int'(c);
      for (int i = 0; i < n; i++) begin
        e.cy = v[0];
        v = (v >> 1) | ((ar && sg) ? (32'd1 << (w - 1)) : 32'd0);
      end
    end
    if (n > w) e.cy = 1'b0;
    e.d = v;
    e.s = v[w-1];
    e.z = (v == 32'd0);
    return e;
  endfunction

  function automatic string classify(input logic [7:0] c, input logic [1:0] wc,
                                     input logic ar);
    int w;
    int n;
    w = (wc == 2'd0) ? 8 : (wc == 2'd1) ? 16 : 32;
    n = c[7] ? 256 - int'(c) : int'(c);
    if (c == 8'd0) return "R3";
    if (n > w) return "R11";
    if (!c[7]) return ar ? "R7" : "R4";
    return ar ? "R8" : "R5";
  endfunction

  task automatic drive(input logic [31:0] d, input logic [7:0] c,
                       input logic [1:0] wc, input logic ar, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_count = c; in_width = wc; in_arith = ar;
    e = model(d, c, wc, ar);
    e.tag = (tag == "") ? classify(c, wc, ar) : tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 32'hDEAD_BEEF;
      in_count = 8'h05;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1", "unexpected result", out_data, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_data == e.d, e.tag, "data", out_data, e.d);
          check(out_carry == e.cy, e.tag, "carry", 32'(out_carry), 32'(e.cy));
          check(out_ovf == e.ov, e.arl ? "R6" : e.tag, "overflow",
                32'(out_ovf), 32'(e.ov));
          check({out_sign, out_zero} == {e.s, e.z}, "R9", "sign/zero",
                32'({out_sign, out_zero}), 32'({e.s, e.z}));
        end
        last_data = out_data;
        have_last = 1'b1;
      end else if (have_last) begin
        check(out_data == last_data, "R1", "hold while idle", out_data, last_data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({out_valid, out_data, out_carry, out_ovf, out_sign, out_zero} == '0,
          "R1", "reset state", out_data, 32'h0);

    // R3 zero count, value and flags
    drive(32'h0000_0085, 8'h00, 2'd0, 1'b1, "R3");
    drive(32'h0000_0000, 8'h00, 2'd1, 1'b0, "R3");
    idle(2);
    // R2 signed count interpretation
    drive(32'h0000_0001, 8'h7F, 2'd2, 1'b0, "R2");
    drive(32'h8000_0000, 8'h80, 2'd2, 1'b1, "R2");
    drive(32'h0000_00F0, 8'hFC, 2'd0, 1'b0, "R2");
    drive(32'h0000_000F, 8'h04, 2'd0, 1'b0, "R2");
    // R4 logical left, boundaries n=W, n=W+1
    drive(32'h0000_0081, 8'd1, 2'd0, 1'b0, "R4");
    drive(32'h0000_0001, 8'd8, 2'd0, 1'b0, "R4");
    drive(32'h0000_FFFF, 8'd9, 2'd0, 1'b0, "R11");
    // R5 logical right
    drive(32'h8000_0001, 8'hFF, 2'd2, 1'b0, "R5");
    drive(32'h0000_8000, 8'hF0, 2'd1, 1'b0, "R5");
    drive(32'h0000_8000, 8'hEF, 2'd1, 1'b0, "R11");
    idle(1);
    // R6 arithmetic left overflow, both signs
    drive(32'h0000_0040, 8'd2, 2'd0, 1'b1, "R6");
    drive(32'h0000_00C0, 8'd2, 2'd0, 1'b1, "R6");
    drive(32'h0000_00A0, 8'd2, 2'd0, 1'b1, "R6");
    drive(32'h0000_3FFF, 8'd1, 2'd1, 1'b1, "R6");
    drive(32'hFFFF_FFFF, 8'd40, 2'd2, 1'b1, "R6");
    // R7 arithmetic left result and carry
    drive(32'h4000_0001, 8'd31, 2'd2, 1'b1, "R7");
    drive(32'h0000_0001, 8'd16, 2'd1, 1'b1, "R7");
    // R8 arithmetic right, sign fill
    drive(32'h0000_0080, 8'hFD, 2'd0, 1'b1, "R8");
    drive(32'h0000_8001, 8'hF0, 2'd1, 1'b1, "R8");
    drive(32'h8000_0000, 8'hC0, 2'd2, 1'b1, "R8");
    drive(32'h7FFF_FFFF, 8'hE0, 2'd2, 1'b1, "R8");
    idle(3);
    // R10 width codes and ignored upper bits
    drive(32'hABCD_1281, 8'd1, 2'd0, 1'b0, "R10");
    drive(32'hABCD_8001, 8'hFF, 2'd1, 1'b1, "R10");
    drive(32'hF000_000F, 8'd4, 2'd3, 1'b0, "R10");
    drive(32'hF000_000F, 8'd4, 2'd2, 1'b0, "R10");
    idle(2);

    for (int k = 0; k < 600; k++) begin
      drive($urandom, 8'($urandom), 2'($urandom), 1'($urandom), "");
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(4);

    done = 1'b1;
    check(sb.size() == 0, "R1", "results outstanding", 32'(sb.size()), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule